// File: doc/BRIEF.md
# Two-Level Global History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of the outcomes of recently resolved conditional branches and a table of 2-bit saturating counters. A fetch PC presented on the lookup port selects one counter, and the prediction comes back combinationally in the same cycle. A resolved branch presented on the update port trains the counter it maps to and then pushes its outcome into the history.

The counter is chosen by combining the history with PC bits, after the instruction-alignment bits of the PC are dropped. A build-time parameter picks one of two combining schemes. The first places the history bits above the PC bits. The second XORs the history into the PC bits, which uses a smaller table but lets unrelated branches share a counter.

Top module: `gh_predictor`

## Requirements
- R1: After reset every counter holds 01 and the history holds all zeros, so every lookup predicts not-taken.
- R2: A lookup predicts taken when the selected counter is 10 or 11, and not-taken when it is 00 or 01. The prediction is the counter's upper bit.
- R3: An update with outcome taken increments the selected counter and saturates at 11. An update with outcome not-taken decrements it and saturates at 00.
- R4: Each update shifts its outcome into bit 0 of the history (taken = 1, not-taken = 0) and drops the oldest bit. A cycle without an update leaves the history unchanged.
- R5: The counter an update trains is selected with the history as it was before that update's own outcome is shifted in.
- R6: In concatenation mode (IDX_MODE = IDX_CONCAT) the index is {history, pcField}, where pcField = PC[ALIGN_BITS+PC_BITS-1:ALIGN_BITS] and the history occupies the upper bits.
- R7: In XOR mode (IDX_MODE = IDX_XOR) the index is pcField XOR history, with the history zero-extended into the low bits of pcField.
- R8: PC bits below ALIGN_BITS, and PC bits above the pcField, have no effect on the prediction.
- R9: When a lookup and an update select the same counter in one cycle, the lookup returns the counter value from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupPc | input | PC_W | Fetch PC to predict |
| predictTaken | output | 1 | Prediction for lookupPc, 1 = taken |
| updateValid | input | 1 | A resolved conditional branch is presented this cycle |
| updatePc | input | PC_W | PC of the resolved branch |
| updateTaken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The hardest situation to reach is a counter saturating at 00 or 11, because every update also moves the history and so the next update usually lands on a different counter. The stimulus gets there by repeating one outcome long enough that the history settles at all ones or all zeros. After that, further updates at the same PC keep hitting one counter. After driving a counter to 00, the bench sends one taken update and then enough not-taken updates at another PC to bring the history back to zero, so a reading of not-taken shows that no wrap occurred. A same-cycle lookup and update of one counter, and long random streams over a few repeating PCs compared every cycle against a behavioural model of both index schemes, cover the rest.

// File: rtl/gh_pkg.sv
package gh_pkg;

  typedef enum logic {
    IDX_CONCAT = 1'b0,
    IDX_XOR    = 1'b1
  } idxMode_e;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic write;     // change the counter at the update index
    logic countUp;   // direction of that change
    logic shift;     // push an outcome into the history
    logic shiftBit;  // outcome to push
  } ghStrobe_t;

  localparam logic [1:0] CTR_INIT = 2'b01;
  localparam logic [1:0] CTR_MAX  = 2'b11;
  localparam logic [1:0] CTR_MIN  = 2'b00;

endpackage

// File: rtl/gh_index.sv
module gh_index #(
  parameter int PC_W       = 32,
  parameter int HIST_W     = 4,
  parameter int PC_BITS    = 4,
  parameter int ALIGN_BITS = 2,
  parameter gh_pkg::idxMode_e IDX_MODE = gh_pkg::IDX_CONCAT,
  parameter int IDX_W      = HIST_W + PC_BITS
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);

  logic [PC_BITS-1:0] pcField;
  assign pcField = pc[ALIGN_BITS +: PC_BITS];

  // Alignment bits and bits above the field play no part in the index.
  logic unusedPcBits;
  assign unusedPcBits = ^{pc[PC_W-1:ALIGN_BITS+PC_BITS], pc[ALIGN_BITS-1:0]};

  generate
    if (IDX_MODE == gh_pkg::IDX_CONCAT) begin : g_concat
      assign idx = {hist, pcField};
    end else begin : g_xor
      logic [PC_BITS-1:0] histExt;
      always_comb begin
        histExt = '0;
        histExt[HIST_W-1:0] = hist;
      end
      assign idx = pcField ^ histExt;
    end
  endgenerate

endmodule

// File: rtl/gh_ctrl.sv
module gh_ctrl (
  input  logic              clk,
  input  logic              rstN,
  input  logic              updateValid,
  input  logic              updateTaken,
  input  logic [1:0]        updCtr,
  output gh_pkg::ghStrobe_t strb
);
  import gh_pkg::*;

  logic atCeiling;
  logic atFloor;
  assign atCeiling = (updCtr == CTR_MAX);
  assign atFloor   = (updCtr == CTR_MIN);

  always_comb begin
    strb.shift    = updateValid;
    strb.shiftBit = updateTaken;
    strb.countUp  = updateTaken;
    // A saturated counter is left alone instead of wrapping.
    strb.write    = updateValid && (updateTaken ? !atCeiling : !atFloor);
  end

  // R3: a write never pushes a counter past either end.
  a_r3_no_wrap_up: assert property (@(posedge clk) disable iff (!rstN)
    (strb.write && strb.countUp) |-> (updCtr != CTR_MAX));
  a_r3_no_wrap_down: assert property (@(posedge clk) disable iff (!rstN)
    (strb.write && !strb.countUp) |-> (updCtr != CTR_MIN));
  // R4: the history moves only for an update.
  a_r4_shift_needs_update: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |-> updateValid);

endmodule

// File: rtl/gh_datapath.sv
module gh_datapath #(
  parameter int HIST_W = 4,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  gh_pkg::ghStrobe_t strb,
  input  logic [IDX_W-1:0]  lookupIdx,
  input  logic [IDX_W-1:0]  updateIdx,
  output logic [HIST_W-1:0] hist,
  output logic [1:0]        updCtr,
  output logic              predictTaken
);
  import gh_pkg::*;

  localparam int TBL_SIZE = 1 << IDX_W;

  logic [1:0] ctrTable [TBL_SIZE];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist <= '0;
      for (int i = 0; i < TBL_SIZE; i++) ctrTable[i] <= CTR_INIT;
    end else begin
      if (strb.write)
        ctrTable[updateIdx] <= strb.countUp ? ctrTable[updateIdx] + 2'd1
                                            : ctrTable[updateIdx] - 2'd1;
      if (strb.shift)
        hist <= {hist[HIST_W-2:0], strb.shiftBit};
    end
  end

  // Reads see the registered table, so a same-cycle write is not visible yet.
  assign updCtr       = ctrTable[updateIdx];
  assign predictTaken = ctrTable[lookupIdx][1];

  // R4: outcome enters at bit 0, oldest bit leaves.
  a_r4_shift_in: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |=> (hist == {$past(hist[HIST_W-2:0]), $past(strb.shiftBit)}));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shift |=> $stable(hist));

endmodule

// File: rtl/gh_predictor.sv
module gh_predictor #(
  parameter int PC_W       = 32,
  parameter int HIST_W     = 4,
  parameter int PC_BITS    = 4,
  parameter int ALIGN_BITS = 2,
  parameter gh_pkg::idxMode_e IDX_MODE = gh_pkg::IDX_CONCAT
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  output logic            predictTaken,
  input  logic            updateValid,
  input  logic [PC_W-1:0] updatePc,
  input  logic            updateTaken
);
  import gh_pkg::*;

  // XOR mode needs HIST_W <= PC_BITS; the index then has PC_BITS bits.
  localparam int IDX_W = (IDX_MODE == IDX_CONCAT) ? HIST_W + PC_BITS : PC_BITS;

  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  lookupIdx;
  logic [IDX_W-1:0]  updateIdx;
  logic [1:0]        updCtr;
  ghStrobe_t         strb;

  gh_index #(
    .PC_W(PC_W), .HIST_W(HIST_W), .PC_BITS(PC_BITS),
    .ALIGN_BITS(ALIGN_BITS), .IDX_MODE(IDX_MODE), .IDX_W(IDX_W)
  ) u_lookupIndex (
    .pc(lookupPc), .hist(hist), .idx(lookupIdx)
  );

  // R5: trained entry uses the history held before this update's shift.
  gh_index #(
    .PC_W(PC_W), .HIST_W(HIST_W), .PC_BITS(PC_BITS),
    .ALIGN_BITS(ALIGN_BITS), .IDX_MODE(IDX_MODE), .IDX_W(IDX_W)
  ) u_updateIndex (
    .pc(updatePc), .hist(hist), .idx(updateIdx)
  );

  gh_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .updateValid(updateValid), .updateTaken(updateTaken),
    .updCtr(updCtr), .strb(strb)
  );

  gh_datapath #(.HIST_W(HIST_W), .IDX_W(IDX_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .lookupIdx(lookupIdx), .updateIdx(updateIdx),
    .hist(hist), .updCtr(updCtr), .predictTaken(predictTaken)
  );

endmodule

// File: tb/gh_predictor_test.sv
`timescale 1ns/1ps
module gh_predictor_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lookupPc = '0;
  logic        updateValid = 1'b0;
  logic [31:0] updatePc = '0;
  logic        updateTaken = 1'b0;
  logic        predCat;
  logic        predXor;

  always #2 clk = ~clk;  // 250 MHz

  gh_predictor #(.IDX_MODE(gh_pkg::IDX_CONCAT)) uut (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predictTaken(predCat),
    .updateValid(updateValid), .updatePc(updatePc), .updateTaken(updateTaken)
  );

  gh_predictor #(.IDX_MODE(gh_pkg::IDX_XOR)) uutXor (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predictTaken(predXor),
    .updateValid(updateValid), .updatePc(updatePc), .updateTaken(updateTaken)
  );

  // Behavioural model: plain integer arrays and an integer history.
  int modelCat [256];
  int modelXor [16];
  int modelHist;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic int fieldOf(input logic [31:0] pc);
    return int'((pc / 4) % 16);
  endfunction
  function automatic int catIdx(input logic [31:0] pc);
    return modelHist * 16 + fieldOf(pc);
  endfunction
  function automatic int xorIdx(input logic [31:0] pc);
    return fieldOf(pc) ^ modelHist;
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic modelTrain(input logic [31:0] pc, input bit taken);
    int ic;
    int ix;
    ic = catIdx(pc);
    ix = xorIdx(pc);
    if (taken) begin
      if (modelCat[ic] < 3) modelCat[ic]++;
      if (modelXor[ix] < 3) modelXor[ix]++;
    end else begin
      if (modelCat[ic] > 0) modelCat[ic]--;
      if (modelXor[ix] > 0) modelXor[ix]--;
    end
    modelHist = ((modelHist * 2) + int'(taken)) % 16;
  endtask

  // One cycle: drive, compare both designs with the model, advance the model.
  task automatic step(input logic [31:0] lpc, input bit v, input logic [31:0] upc,
                      input bit t, input string req);
    @(negedge clk);
    lookupPc = lpc; updateValid = v; updatePc = upc; updateTaken = t;
    #1;
    check(req, "concat model", predCat, logic'(modelCat[catIdx(lpc)] >= 2));
    check(req, "xor model",    predXor, logic'(modelXor[xorIdx(lpc)] >= 2));
    if (v) modelTrain(upc, t);
  endtask

  task automatic peek(input logic [31:0] lpc, input string req,
                      input logic expCat, input logic expXor, input bit useXor);
    @(negedge clk);
    lookupPc = lpc; updateValid = 1'b0; #1;
    check(req, "concat direct", predCat, expCat);
    if (useXor) check(req, "xor direct", predXor, expXor);
  endtask

  localparam logic [31:0] PC_A = 32'h0000_0100;  // field 0
  localparam logic [31:0] PC_B = 32'h0000_0204;  // field 1
  localparam logic [31:0] PC_C = 32'h0000_0308;  // field 2

  initial begin
    for (int i = 0; i < 256; i++) modelCat[i] = 1;
    for (int i = 0; i < 16; i++) modelXor[i] = 1;
    modelHist = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: everything starts not-taken.
    peek(32'h0, "R1", 1'b0, 1'b0, 1'b1);
    peek(32'h3C, "R1", 1'b0, 1'b0, 1'b1);
    peek(32'hFFFF_FFF0, "R1", 1'b0, 1'b0, 1'b1);

    // R3/R4: taken stream settles history at 1111, then saturates one counter.
    for (int i = 0; i < 7; i++) step(PC_A, 1'b1, PC_A, 1'b1, "R3");
    // R2/R8: counter at 11 predicts taken, whatever the alignment bits.
    peek(PC_A,     "R2", 1'b1, 1'b1, 1'b1);
    peek(PC_A + 1, "R8", 1'b1, 1'b1, 1'b1);
    peek(PC_A + 3, "R8", 1'b1, 1'b1, 1'b1);
    peek(PC_A | 32'h8000_0000, "R8", 1'b1, 1'b1, 1'b1);
    // R6/R7: next field is an untrained entry in both schemes.
    peek(PC_A + 4, "R6", 1'b0, 1'b0, 1'b1);

    // R3: drive counter at PC_B/hist 0000 to 00, keep it there, then one taken.
    for (int i = 0; i < 7; i++) step(PC_B, 1'b1, PC_B, 1'b0, "R3");
    step(PC_B, 1'b1, PC_B, 1'b1, "R3");
    for (int i = 0; i < 4; i++) step(PC_C, 1'b1, PC_C, 1'b0, "R4");
    // History back to 0000: the concat entry must read 01 (no wrap).
    peek(PC_B, "R3", 1'b0, 1'b0, 1'b0);

    // R9: lookup and update of the same entry in one cycle see the old value.
    step(PC_B, 1'b1, PC_B, 1'b1, "R9");
    @(negedge clk);
    lookupPc = PC_B; updateValid = 1'b0; #1;
    // R5: history is now 0001, so PC_B reads a different, untrained entry.
    check("R5", "concat direct", predCat, 1'b0);

    // Mixed directed patterns, then a long random stream over few PCs.
    for (int i = 0; i < 40; i++)
      step(PC_C, 1'b1, (i % 3 == 0) ? PC_A : PC_C, (i % 5) != 0, "R4");
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] lp;
      logic [31:0] up;
      lp = {$urandom_range(0, 7), 2'($urandom)} ;
      up = {$urandom_range(0, 7), 2'($urandom)};
      step(lp, 1'($urandom_range(0, 3) != 0), up, 1'($urandom_range(0, 9) < 7),
           (i % 2 == 0) ? "R6" : "R7");
    end
    step(PC_A, 1'b0, PC_A, 1'b0, "R4");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule